// File: doc/BRIEF.md
# FitzHugh-Nagumo Neuron Step Unit

This block advances one two-variable FitzHugh-Nagumo neuron by a single forward-Euler time step for each accepted request. A request carries the present membrane value v, the present recovery value w and the stimulus current I. The result is the next v, the next w and a flag that marks an upward threshold crossing. All values are 16-bit signed fixed point with 12 fractional bits, so 1.0 is 4096. The model is dv = v − g(v) − w + I and dw = ε·(v + a − b·w), with step dt = 1/16, ε ≈ 0.078125, a ≈ 0.7 and b = 0.75. Every product with a model constant is built from arithmetic shifts and additions, so the unit contains no multiplier. The cubic term v³/3 is replaced by g(v), an odd, piecewise-linear curve shaped like a scaled hyperbolic sine.

The datapath has three register stages: the nonlinearity and the b·w term, then the two derivatives, then the Euler update with saturation and threshold detection. The unit takes one request per cycle through a valid/ready handshake. A stall at the output freezes the whole pipeline. A caller that keeps one neuron's state in memory feeds each result back as the next request. Under a constant stimulus of 0.5 the neuron then fires periodically.

Top module: `fhn_neuron`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and no result appears until a request has been accepted.
- R2: A request accepted at a rising edge (in_valid and in_ready high) appears with out_valid high after the second following rising edge, provided out_ready stays high. Back-to-back requests give results on consecutive cycles.
- R3: The next v is v + ((v − g(v) − w + I) >>> 4), using arithmetic right shifts with floor rounding. g is odd, g(−x) = −g(x). For m = |v| in LSBs, g is: m>>4 + m>>6 below 2048; 160 + (m−2048)>>1 + (m−2048)>>4 below 4096; 1312 + (m−4096) + (m−4096)>>1 below 6144; 4384 + 3·(m−6144) below 8192; and 10528 + 5·(m−8192) from 8192 upward.
- R4: The next w is w + (((d>>>4) + (d>>>6)) >>> 4), where d = v + 2867 − ((w>>>1) + (w>>>2)).
- R5: Intermediate sums never wrap. The next v and the next w saturate to the range −32768 to 32767.
- R6: out_spike is 1 together with a result exactly when the request's v was below 4096 and the next v is 4096 or more. It is never high without out_valid.
- R7: While out_valid is 1 and out_ready is 0, the outputs hold their values and in_ready is 0. Every accepted request produces exactly one result, in acceptance order.
- R8: When each result is fed back as the next request with I fixed at 2048 (0.5), spikes recur with intervals longer than 50 steps. Successive intervals differ by at most 5 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_v | input | 16 | Present membrane value, signed Q4.12 |
| in_w | input | 16 | Present recovery value, signed Q4.12 |
| in_i | input | 16 | Stimulus current, signed Q4.12 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_v | output | 16 | Next membrane value, signed Q4.12 |
| out_w | output | 16 | Next recovery value, signed Q4.12 |
| out_spike | output | 1 | Upward crossing of 1.0 in this step |

## Verification
A wrong slope or base in one segment of the nonlinearity shows in out_v as soon as a request with v in that segment reaches the output, three edges after it is accepted. The bench therefore places requests in every segment on both signs. Errors in the recovery path change out_w by only a few LSBs per step. In closed loop, such errors build up and visibly shift the spike interval within a few hundred steps. A dropped or duplicated pipeline valid bit shows at once as a missing, extra or out-of-order result against the bench's expected queue. It is most exposed when output stalls are interleaved with bursts.

// File: rtl/fhn_neuron.sv
module fhn_neuron #(
  parameter int W        = 16,
  parameter int FRAC     = 12,
  parameter int A_Q      = 2867,
  parameter int DT_SH    = 4,
  parameter int EPS_SH_A = 4,
  parameter int EPS_SH_B = 6,
  parameter int B_SH_A   = 1,
  parameter int B_SH_B   = 2,
  parameter int SPIKE_TH = 1 << FRAC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_v,
  input  logic signed [W-1:0] in_w,
  input  logic signed [W-1:0] in_i,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_v,
  output logic signed [W-1:0] out_w,
  output logic                out_spike
);

  localparam int CW = W + 4;
  localparam int DW = CW + 2;
  localparam int WW = W + 2;

  localparam logic [CW-1:0] HALF = CW'(1) << (FRAC - 1);
  localparam logic [CW-1:0] BP2  = HALF << 1;
  localparam logic [CW-1:0] BP3  = BP2 + HALF;
  localparam logic [CW-1:0] BP4  = BP2 << 1;
  localparam logic [CW-1:0] G1   = (HALF >> 4) + (HALF >> 6);
  localparam logic [CW-1:0] G2   = G1 + (HALF >> 1) + (HALF >> 4);
  localparam logic [CW-1:0] G3   = G2 + HALF + (HALF >> 1);
  localparam logic [CW-1:0] G4   = G3 + (HALF << 1) + HALF;

  localparam logic signed [DW-1:0] SMAX = {{(DW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [DW-1:0] SMIN = {{(DW-W+1){1'b1}}, {(W-1){1'b0}}};

  function automatic logic [CW-1:0] fit(input logic [W:0] mag);
    logic [CW-1:0] x, d;
    x = CW'(mag);
    d = '0;
    if (x < HALF) begin
      fit = (x >> 4) + (x >> 6);
    end else if (x < BP2) begin
      d = x - HALF;
      fit = G1 + (d >> 1) + (d >> 4);
    end else if (x < BP3) begin
      d = x - BP2;
      fit = G2 + d + (d >> 1);
    end else if (x < BP4) begin
      d = x - BP3;
      fit = G3 + (d << 1) + d;
    end else begin
      d = x - BP4;
      fit = G4 + (d << 2) + d;
    end
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [DW-1:0] x);
    if (x > SMAX)      sat = SMAX[W-1:0];
    else if (x < SMIN) sat = SMIN[W-1:0];
    else               sat = x[W-1:0];
  endfunction

  logic adv;
  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  logic [W:0]               mag;
  logic [CW-1:0]            g_abs;
  logic signed [CW-1:0]     cub_c;
  logic signed [W:0]        bw_c;

  assign mag   = in_v[W-1] ? (~{1'b1, in_v} + (W+1)'(1)) : {1'b0, in_v};
  assign g_abs = fit(mag);
  assign cub_c = in_v[W-1] ? -$signed(g_abs) : $signed(g_abs);
  assign bw_c  = ((W+1)'(in_w) >>> B_SH_A) + ((W+1)'(in_w) >>> B_SH_B);

  logic                 s1_vld;
  logic signed [W-1:0]  s1_v, s1_w, s1_i;
  logic signed [CW-1:0] s1_cub;
  logic signed [W:0]    s1_bw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_v   <= '0;
      s1_w   <= '0;
      s1_i   <= '0;
      s1_cub <= '0;
      s1_bw  <= '0;
    end else if (adv) begin
      s1_vld <= in_valid;
      s1_v   <= in_v;
      s1_w   <= in_w;
      s1_i   <= in_i;
      s1_cub <= cub_c;
      s1_bw  <= bw_c;
    end
  end

  logic signed [DW-1:0] dv_c;
  logic signed [WW-1:0] dw_c;

  assign dv_c = DW'(s1_v) - DW'(s1_cub) - DW'(s1_w) + DW'(s1_i);
  assign dw_c = WW'(s1_v) + WW'(A_Q) - WW'(s1_bw);

  logic                 s2_vld;
  logic signed [W-1:0]  s2_v, s2_w;
  logic signed [DW-1:0] s2_dv;
  logic signed [WW-1:0] s2_dw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s2_v   <= '0;
      s2_w   <= '0;
      s2_dv  <= '0;
      s2_dw  <= '0;
    end else if (adv) begin
      s2_vld <= s1_vld;
      s2_v   <= s1_v;
      s2_w   <= s1_w;
      s2_dv  <= dv_c;
      s2_dw  <= dw_c;
    end
  end

  logic signed [DW-1:0] vsum;
  logic signed [WW-1:0] wstep, wsum;
  logic signed [W-1:0]  v_nx, w_nx;

  assign vsum  = DW'(s2_v) + (s2_dv >>> DT_SH);
  assign wstep = ((s2_dw >>> EPS_SH_A) + (s2_dw >>> EPS_SH_B)) >>> DT_SH;
  assign wsum  = WW'(s2_w) + wstep;
  assign v_nx  = sat(vsum);
  assign w_nx  = sat(DW'(wsum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_v     <= '0;
      out_w     <= '0;
      out_spike <= 1'b0;
    end else if (adv) begin
      out_valid <= s2_vld;
      out_v     <= v_nx;
      out_w     <= w_nx;
      out_spike <= s2_vld && (s2_v < SPIKE_TH) && (v_nx >= SPIKE_TH);
    end
  end

endmodule

// File: rtl/fhn_neuron_chk.sv
module fhn_neuron_chk #(
  parameter int W        = 16,
  parameter int SPIKE_TH = 4096
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] out_v,
  input logic signed [W-1:0] out_w,
  input logic                out_spike
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_v) && $stable(out_w) && $stable(out_spike)));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 2'd3) && $past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1))
      |-> out_valid);

  p_spike_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_spike |-> out_valid);

  p_spike_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_spike |-> (out_v >= SPIKE_TH));

endmodule

bind fhn_neuron fhn_neuron_chk #(.W(W), .SPIKE_TH(SPIKE_TH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_v(out_v), .out_w(out_w),
  .out_spike(out_spike)
);

// File: tb/fhn_neuron_tb_top.sv
`timescale 1ns/1ps
module fhn_neuron_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_v = '0, in_w = '0, in_i = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_v, out_w;
  logic out_spike;

  always #4 clk = ~clk;

  fhn_neuron dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_v(in_v), .in_w(in_w), .in_i(in_i), .out_valid(out_valid),
    .out_ready(out_ready), .out_v(out_v), .out_w(out_w), .out_spike(out_spike)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int n_out = 0;
  int last_v, last_w;
  bit last_sp;
  bit done = 0;
  int exp_v[$], exp_w[$];
  bit exp_s[$];
  int xfer_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clamp16(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic void ref_step(input int v, input int w, input int i,
                                   output int nv, output int nw, output bit sp);
    int m, y, d, dv, dw, e;
    m = (v < 0) ? -v : v;
    if (m < 2048) y = (m >> 4) + (m >> 6);
    else if (m < 4096) begin d = m - 2048; y = 160 + (d >> 1) + (d >> 4); end
    else if (m < 6144) begin d = m - 4096; y = 1312 + d + (d >> 1); end
    else if (m < 8192) begin d = m - 6144; y = 4384 + 3 * d; end
    else begin d = m - 8192; y = 10528 + 5 * d; end
    if (v < 0) y = -y;
    dv = v - y - w + i;
    nv = clamp16(v + (dv >>> 4));
    dw = v + 2867 - ((w >>> 1) + (w >>> 2));
    e  = ((dw >>> 4) + (dw >>> 6)) >>> 4;
    nw = clamp16(w + e);
    sp = (v < 4096) && (nv >= 4096);
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_v.size() == 0) begin
        chk_int("R7 result without request", 1, 0);
      end else begin
        chk_int("R3 next v", out_v, exp_v.pop_front());
        chk_int("R4 next w", out_w, exp_w.pop_front());
        chk_int("R6 spike flag", out_spike, exp_s.pop_front());
      end
      last_v = out_v;
      last_w = out_w;
      last_sp = out_spike;
      n_out++;
      xfer_cyc.push_back(cyc);
    end
  end

  task automatic send(input int v, input int w, input int i);
    int nv, nw;
    bit sp;
    @(negedge clk);
    in_v = 16'(v);
    in_w = 16'(w);
    in_i = 16'(i);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    ref_step(v, w, i, nv, nw, sp);
    exp_v.push_back(nv);
    exp_w.push_back(nw);
    exp_s.push_back(sp);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_v.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_out(input int target);
    while (n_out < target) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk_int("R1 out_valid after reset", out_valid, 0);
    chk_int("R1 in_ready after reset", in_ready, 1);
    repeat (3) @(negedge clk);
    #1;
    chk_int("R1 no result while idle", out_valid, 0);
    chk_int("R1 output count while idle", n_out, 0);
  endtask

  task automatic t_latency();
    send(1000, 0, 0);
    chk_int("R2 request accepted", in_ready, 1);
    idle();
    #1 chk_int("R2 not valid after 1 edge", out_valid, 0);
    @(negedge clk);
    #1 chk_int("R2 not valid after 2 edges", out_valid, 0);
    @(negedge clk);
    #1 chk_int("R2 valid after 3 edges", out_valid, 1);
    drain();
  endtask

  task automatic t_segments();
    int vals[12] = '{1000, -1000, 3000, -3000, 5000, -5000, 7000, -7000,
                     12000, -12000, 32767, -32768};
    int k0;
    k0 = xfer_cyc.size();
    foreach (vals[k]) send(vals[k], (k * 977) - 5000, 2048 - k * 300);
    idle();
    drain();
    chk_int("R2 burst results on consecutive cycles",
            xfer_cyc[xfer_cyc.size()-1] - xfer_cyc[k0], 11);
  endtask

  task automatic t_spike();
    send(4000, 0, 4096);
    idle();
    drain();
    chk_int("R6 crossing v", last_v, 4427);
    chk_int("R4 crossing w", last_w, 33);
    chk_int("R6 crossing flag", last_sp, 1);
    send(4096, 0, 4096);
    idle();
    drain();
    chk_int("R3 above threshold v", last_v, 4526);
    chk_int("R6 no flag when already above", last_sp, 0);
  endtask

  task automatic t_saturate();
    send(32767, 32767, 0);
    idle();
    drain();
    chk_int("R5 w clamps high", last_w, 32767);
    send(-32768, -32768, 0);
    idle();
    drain();
    chk_int("R5 w clamps low", last_w, -32768);
  endtask

  task automatic t_stall();
    int n0, hv, hw;
    n0 = n_out;
    send(2000, 100, 500);
    send(-2500, 300, 0);
    send(6500, -700, 1000);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk_int("R7 valid held in stall", out_valid, 1);
    chk_int("R7 in_ready low in stall", in_ready, 0);
    hv = out_v;
    hw = out_w;
    repeat (2) @(negedge clk);
    #1;
    chk_int("R7 v held in stall", out_v, hv);
    chk_int("R7 w held in stall", out_w, hw);
    out_ready = 1'b1;
    drain();
    chk_int("R7 all stalled results delivered", n_out - n0, 3);
    n0 = n_out;
    fork
      begin
        for (int k = 0; k < 6; k++) send(k * 1500 - 4000, k * 400, 1024);
        idle();
      end
      begin
        for (int k = 0; k < 14; k++) begin
          @(negedge clk);
          out_ready = (k % 3) != 1;
        end
        out_ready = 1'b1;
      end
    join
    drain();
    chk_int("R7 no loss under toggling ready", n_out - n0, 6);
  endtask

  task automatic t_periodic();
    int v, w, n0, n, i1, i2, df;
    int sp_at[$];
    v = -6144;
    w = 0;
    for (int k = 0; k < 4000; k++) begin
      n0 = n_out;
      send(v, w, 2048);
      idle();
      wait_out(n0 + 1);
      v = last_v;
      w = last_w;
      if (last_sp) sp_at.push_back(k);
    end
    n = sp_at.size();
    chk_int("R8 at least four spikes", n >= 4, 1);
    if (n >= 4) begin
      i1 = sp_at[n-1] - sp_at[n-2];
      i2 = sp_at[n-2] - sp_at[n-3];
      df = (i1 > i2) ? i1 - i2 : i2 - i1;
      chk_int("R8 interval longer than 50 steps", i1 > 50, 1);
      chk_int("R8 interval repeats within 5 steps", df <= 5, 1);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_segments();
    t_spike();
    t_saturate();
    t_stall();
    t_periodic();
    chk_int("R7 expected queue empty at end", exp_v.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(64'd8 * 64'd200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule